// File: doc/BRIEF.md
# Packed Colour Palette RAM

This block is a 256-colour lookup table for a display pipeline. The colour entries are 15-bit RGB values, and two of them are packed into each 32-bit bus word, so the table fills 128 words. Software reaches the table through a 12-bit byte-addressed register window. Writes change the raw words and honour per-byte strobes. Reads return the raw words exactly as written, including the otherwise unused top bit of each entry.

The pixel path has its own lookup port. It takes an 8-bit colour index and, one cycle later, returns a 24-bit colour. To build that colour, the block picks the addressed half of the word, drops the top bit, and widens each 5-bit component to 8 bits by appending three zeros. Both the bus side and the lookup side read the same storage. They may act in the same cycle, including on the same word.

Top module: `clut_palette`

## Requirements
- R1: After a synchronous active-low reset, `bus_rdata` and `lut_rgb` are both zero.
- R2: The table occupies byte addresses 0x200 through 0x3FF, and word n sits at address 0x200 + 4n, so the word index is address bits [8:2]. Address bits [1:0] are ignored. A write outside the window changes no word. A read outside the window returns zero.
- R3: Word n holds colour index 2n in bits [15:0] and colour index 2n+1 in bits [31:16].
- R4: Each 16-bit entry has red in bits [4:0], green in [9:5] and blue in [14:10]. The lookup output is {red, 3'b000, green, 3'b000, blue, 3'b000}, with red in `lut_rgb[23:16]`, green in [15:8] and blue in [7:0].
- R5: Bit 15 of an entry has no effect on the lookup output.
- R6: A bus read inside the window returns, on the next cycle, the full 32-bit word last written, bit 15 and bit 31 included. In a cycle that follows no window read, `bus_rdata` is zero.
- R7: Byte strobe k (`bus_be[k]`) gates bits [8k+7:8k] of a write. Bytes whose strobe is clear keep their earlier value, so a single entry can be rewritten on its own.
- R8: `lut_rgb` reflects the index presented one cycle earlier. A lookup presented in the cycle after a write sees the new data. A lookup presented in the same cycle as a write to its word sees the old data.
- R9: When a bus read and a bus write target the same word in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Bus write request this cycle |
| bus_rd_en | input | 1 | Bus read request this cycle |
| bus_addr | input | 12 | Byte address of the bus access |
| bus_be | input | 4 | Byte strobes for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after the request |
| lut_index | input | 8 | Colour index to look up |
| lut_rgb | output | 24 | Widened colour for the index of the previous cycle |

## Verification
A bus write and a pixel lookup can land on the same word in the same cycle. A bus read and a bus write to that word can also coincide. The bench provokes both cases with directed steps: it writes a word while looking up one of its halves, and it issues a read and a write to one address together. It then repeats the lookup on the following cycle. A long random phase keeps producing such collisions by drawing lookup indices and bus addresses over a narrow range. The scoreboard computes every expected value from its own copy of the table as it stood before that cycle's write. So the colliding access must show the old contents, and the access on the next cycle must show the new ones.

// File: rtl/clut_pkg.sv
// Shared widths, types and the colour widening function of the palette.
// Assumes a 16-bit entry holding three 5-bit components plus one spare bit.
package clut_pkg;
    localparam int unsigned ENT_W  = 16;
    localparam int unsigned CMP_W  = 5;
    localparam int unsigned OCMP_W = 8;

    typedef logic [ENT_W-1:0] entry_t;

    typedef struct packed {
        logic [OCMP_W-1:0] red;
        logic [OCMP_W-1:0] green;
        logic [OCMP_W-1:0] blue;
    } rgb_t;

    // Widen each 5-bit component with zero fill; the top entry bit is dropped.
    function automatic rgb_t widen(entry_t e);
        rgb_t c;
        c.red   = {e[CMP_W-1:0],         {(OCMP_W-CMP_W){1'b0}}};
        c.green = {e[2*CMP_W-1:CMP_W],   {(OCMP_W-CMP_W){1'b0}}};
        c.blue  = {e[3*CMP_W-1:2*CMP_W], {(OCMP_W-CMP_W){1'b0}}};
        return c;
    endfunction
endpackage

// File: rtl/clut_decode.sv
// Address decode for the palette window.
// Flags whether a byte address falls inside the window and yields the word
// index. Assumes the base address is word aligned.
module clut_decode #(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned WIN_BASE = 12'h200,
    parameter int unsigned WORDS    = 128,
    localparam int unsigned WIDX_W  = $clog2(WORDS)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [WIDX_W-1:0] widx
);
    localparam int unsigned WIN_END = WIN_BASE + WORDS * 4;

    logic [ADDR_W-1:0] off;
    logic              unused_off;

    // Window compare and word index extraction.
    always_comb begin
        hit  = (32'(addr) >= WIN_BASE) && (32'(addr) < WIN_END);
        off  = addr - ADDR_W'(WIN_BASE);
        widx = off[WIDX_W+1:2];
    end

    assign unused_off = ^{off[ADDR_W-1:WIDX_W+2], off[1:0]};
endmodule

// File: rtl/clut_store.sv
// Word storage of the palette with byte-strobed writes.
// It has two registered read ports, one for the bus and one for the lookup
// path. Both ports read before the write at the same edge. The storage itself
// is not reset; only the read registers are.
module clut_store #(
    parameter int unsigned WORDS  = 128,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned WIDX_W = $clog2(WORDS),
    localparam int unsigned BE_W   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WIDX_W-1:0] wr_idx,
    input  logic [BE_W-1:0]   wr_be,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [WIDX_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic [WIDX_W-1:0] lk_idx,
    output logic [DATA_W-1:0] lk_word
);
    logic [DATA_W-1:0] mem [WORDS];
    logic [DATA_W-1:0] wmask;

    // Expand byte strobes into a bit mask, one lane per strobe.
    for (genvar b = 0; b < BE_W; b++) begin : g_lane
        assign wmask[b*8 +: 8] = {8{wr_be[b]}};
    end

    // Merge the strobed bytes into the addressed word.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= (mem[wr_idx] & ~wmask) | (wr_data & wmask);
        end
    end

    // Bus read register; zero when no read is requested.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= mem[rd_idx];
        else            rd_data <= '0;
    end

    // Lookup read register; sampled every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) lk_word <= '0;
        else        lk_word <= mem[lk_idx];
    end

    // R6: with no read in the previous cycle the bus data is zero.
    p_idle_rdata_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> rd_data == '0);
endmodule

// File: rtl/clut_expand.sv
// Entry selection and colour widening for the lookup path.
// Picks one packed entry of a word and widens it to 8 bits per component.
// Assumes the word holds a whole number of entries, lowest entry in the low bits.
module clut_expand
    import clut_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned PER_W = DATA_W / ENT_W,
    localparam int unsigned SEL_W = (PER_W > 1) ? $clog2(PER_W) : 1
) (
    input  logic [DATA_W-1:0] word,
    input  logic [SEL_W-1:0]  sel,
    output rgb_t              rgb
);
    entry_t slot [PER_W];

    // Split the word into its packed entries.
    for (genvar i = 0; i < PER_W; i++) begin : g_slot
        assign slot[i] = word[i*ENT_W +: ENT_W];
    end

    // Select the addressed entry and widen it.
    always_comb begin
        rgb = widen(slot[sel]);
    end
endmodule

// File: rtl/clut_palette.sv
// Packed colour palette: a bus window onto raw storage plus a lookup port.
// The lookup port turns a colour index into a 24-bit colour with one cycle of
// latency. Assumes single-cycle bus requests and synchronous active-low reset.
module clut_palette
    import clut_pkg::*;
#(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned WIN_BASE = 12'h200,
    parameter int unsigned WORDS    = 128,
    localparam int unsigned PER_W   = DATA_W / ENT_W,
    localparam int unsigned IDX_W   = $clog2(WORDS * PER_W),
    localparam int unsigned WIDX_W  = $clog2(WORDS),
    localparam int unsigned SEL_W   = IDX_W - WIDX_W,
    localparam int unsigned BE_W    = DATA_W / 8,
    localparam int unsigned RGB_W   = 3 * OCMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [IDX_W-1:0]  lut_index,
    output logic [RGB_W-1:0]  lut_rgb
);
    logic              hit;
    logic [WIDX_W-1:0] widx;
    logic              st_wr;
    logic              st_rd;
    logic [DATA_W-1:0] lk_word;
    logic [SEL_W-1:0]  sel_q;
    rgb_t              rgb;

    clut_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WORDS(WORDS)) u_dec (
        .addr (bus_addr),
        .hit  (hit),
        .widx (widx)
    );

    // Qualify bus requests with the window hit.
    assign st_wr = bus_wr_en & hit;
    assign st_rd = bus_rd_en & hit;

    clut_store #(.WORDS(WORDS), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (st_wr),
        .wr_idx  (widx),
        .wr_be   (bus_be),
        .wr_data (bus_wdata),
        .rd_en   (st_rd),
        .rd_idx  (widx),
        .rd_data (bus_rdata),
        .lk_idx  (lut_index[IDX_W-1:SEL_W]),
        .lk_word (lk_word)
    );

    // Hold the entry select alongside the registered lookup word.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= lut_index[SEL_W-1:0];
    end

    clut_expand #(.DATA_W(DATA_W)) u_exp (
        .word (lk_word),
        .sel  (sel_q),
        .rgb  (rgb)
    );

    assign lut_rgb = rgb;

    // Cycles since reset, saturating; qualifies the two-cycle history check.
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R2: a read outside the window returns zero.
    p_outwin_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && !hit) |=> bus_rdata == '0);

    // R4: the three zero-filled low bits of each component stay clear.
    p_zero_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lut_rgb[2:0] == 3'b000) && (lut_rgb[10:8] == 3'b000)
        && (lut_rgb[18:16] == 3'b000));

    // R8: a full-word write is seen by a low-entry lookup in the next cycle.
    p_write_visible_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && $past(st_wr, 2) && $past(bus_be, 2) == '1
         && $past(widx, 2) == $past(lut_index[IDX_W-1:SEL_W], 1)
         && $past(lut_index[SEL_W-1:0], 1) == '0)
        |-> lut_rgb[RGB_W-1 -: CMP_W] == $past(bus_wdata[CMP_W-1:0], 2));
endmodule

// File: tb/clut_palette_bench.sv
`timescale 1ns/1ps
module clut_palette_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  lut_index = '0;
    logic [23:0] lut_rgb;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    logic [31:0] model [128];

    typedef struct {
        int          due;
        bit          lchk;
        logic [23:0] lexp;
        string       ltag;
        logic [31:0] rexp;
        string       rtag;
    } exp_t;
    exp_t sb [$];

    always #2.5 clk = ~clk;

    clut_palette u_clut_palette (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr_en (bus_wr_en),
        .bus_rd_en (bus_rd_en),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .lut_index (lut_index),
        .lut_rgb   (lut_rgb)
    );

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [23:0] colour(logic [15:0] e);
        return {e[4:0], 3'b000, e[9:5], 3'b000, e[14:10], 3'b000};
    endfunction

    function automatic bit in_win(logic [11:0] a);
        return (a >= 12'h200) && (a < 12'h400);
    endfunction

    function automatic logic [23:0] model_lookup(logic [7:0] i);
        logic [31:0] w;
        w = model[i[7:1]];
        return colour(i[0] ? w[31:16] : w[15:0]);
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: one bus/lookup cycle, with expectations taken before the write.
    task automatic step(bit wr, bit rd, logic [11:0] a, logic [31:0] d,
                        logic [3:0] be, logic [7:0] li, bit lchk,
                        string ltag, string rtag);
        exp_t e;
        @(posedge clk);
        #1;
        bus_wr_en = wr; bus_rd_en = rd; bus_addr = a;
        bus_wdata = d;  bus_be = be;    lut_index = li;
        e.due  = cyc + 1;
        e.lchk = lchk;
        e.lexp = lchk ? model_lookup(li) : 24'h0;
        e.ltag = ltag;
        e.rexp = (rd && in_win(a)) ? model[a[8:2]] : 32'h0;
        e.rtag = rtag;
        sb.push_back(e);
        if (wr && in_win(a)) begin
            for (int k = 0; k < 4; k++)
                if (be[k]) model[a[8:2]][k*8 +: 8] = d[k*8 +: 8];
        end
    endtask

    // Monitor: compare outputs at the falling edge of the due cycle.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            e = sb.pop_front();
            if (e.lchk)
                check(lut_rgb === e.lexp, e.ltag, 32'(lut_rgb), 32'(e.lexp));
            check(bus_rdata === e.rexp, e.rtag, bus_rdata, e.rexp);
        end
    end

    initial begin
        #500_000;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(bus_rdata === 32'h0, "R1 rdata after reset", bus_rdata, 32'h0);
        check(lut_rgb === 24'h0, "R1 rgb after reset", 32'(lut_rgb), 32'h0);

        // Fill every word; idle read data must stay zero (R6).
        for (int w = 0; w < 128; w++)
            step(1, 0, 12'h200 + 12'(w * 4), {8'(w), 8'hA5, 8'(~w), 8'h3C},
                 4'hF, 8'h0, 0, "", "R6 idle rdata zero");

        // R3/R4: both halves of one word, distinct components.
        step(1, 0, 12'h204, 32'h7C1F_03E0, 4'hF, 8'h0, 1, "R4", "R6");
        step(0, 0, 12'h0, 32'h0, 4'h0, 8'h02, 1, "R3 low entry R4 green", "R6");
        step(0, 0, 12'h0, 32'h0, 4'h0, 8'h03, 1, "R3 high entry R4", "R6");
        // R5: intensity bit set in both halves.
        step(1, 0, 12'h208, 32'h8000_FFFF, 4'hF, 8'h0, 1, "R5", "R6");
        step(0, 1, 12'h208, 32'h0, 4'h0, 8'h04, 1, "R5 intensity low", "R6 raw readback");
        step(0, 0, 12'h0, 32'h0, 4'h0, 8'h05, 1, "R5 intensity high", "R6");
        // R7: byte strobes update one entry alone.
        step(1, 0, 12'h214, 32'h1234_5678, 4'b1100, 8'h0, 1, "R7", "R6");
        step(0, 1, 12'h214, 32'h0, 4'h0, 8'h0A, 1, "R7 untouched entry", "R7 merged word");
        step(1, 0, 12'h216, 32'hDEAD_BEEF, 4'b0010, 8'h0B, 1, "R7", "R6");
        step(0, 1, 12'h214, 32'h0, 4'h0, 8'h0B, 1, "R7 single byte", "R7 single byte word");
        // R2: writes outside the window are dropped; reads there return zero.
        step(1, 0, 12'h100, 32'hFFFF_FFFF, 4'hF, 8'h0, 1, "R2", "R6");
        step(1, 0, 12'h400, 32'hFFFF_FFFF, 4'hF, 8'h0, 1, "R2", "R6");
        step(0, 1, 12'h100, 32'h0, 4'h0, 8'h80, 1, "R2 alias entry", "R2 out-of-window read");
        step(0, 1, 12'h300, 32'h0, 4'h0, 8'h00, 1, "R2 alias entry", "R2 aliased word intact");
        step(0, 1, 12'h1FC, 32'h0, 4'h0, 8'h00, 1, "R2", "R2 below window");
        step(0, 1, 12'h3FF, 32'h0, 4'h0, 8'hFF, 1, "R2 last entry", "R2 top byte address");
        // R8: same-cycle write and lookup see old data, next cycle sees new.
        step(1, 0, 12'h220, 32'h0421_7C00, 4'hF, 8'h10, 1, "R8 same-cycle old", "R6");
        step(0, 0, 12'h0, 32'h0, 4'h0, 8'h10, 1, "R8 next-cycle new", "R6");
        step(0, 0, 12'h0, 32'h0, 4'h0, 8'h11, 1, "R8 next-cycle new high", "R6");
        // R9: read and write to one word together return the old word.
        step(1, 1, 12'h224, 32'hCAFE_F00D, 4'hF, 8'h12, 1, "R8", "R9 read before write");
        step(0, 1, 12'h224, 32'h0, 4'h0, 8'h12, 1, "R8", "R9 new word after");

        // Random collisions over a narrow address range.
        for (int n = 0; n < 600; n++) begin
            logic [11:0] a;
            a = 12'(($urandom_range(32'h1F8, 32'h40C)) & 32'hFFC) | 12'($urandom_range(0, 3));
            step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a, $urandom(),
                 4'($urandom_range(0, 15)),
                 8'((a[8:2] << 1) | 7'($urandom_range(0, 1))) ^ 8'($urandom_range(0, 3)),
                 1, "R8 random lookup", "R9 random read");
        end
        step(0, 0, 12'h0, 32'h0, 4'h0, 8'h0, 1, "R8 tail", "R6 tail");
        repeat (3) @(posedge clk);
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule